// File: doc/BRIEF.md
# Per-Channel Change Detection Unit

This block watches a word of sampled input channels and reports when any of them makes a transition that its own configuration asks for. Each channel picks one of four reactions (ignore, rising only, falling only, or both directions) and one of two capture points: the rising edge of the sample clock, or the falling edge with the value carried over to the next rising edge. All channels are then compared in the rising-edge domain against the sample taken one clock earlier, so a change is resolved to one sample period.

When at least one channel qualifies, the unit raises a one-cycle valid strobe and presents the whole sampled word that held the change. At the same time it starts an event pulse whose length, in clock cycles, comes from a width input. A new qualifying change that arrives while a pulse is still running restarts the pulse and sets a sticky overrun flag, which stays set until reset.

Top module: `chg_detect_unit`

## Requirements
- R1: While reset is held and after it is released with quiet inputs, `hit_valid`, `evt_pulse` and `overrun` are 0, `hit_word` is 0, and the sample history is 0.
- R2: Channel i takes its mode from `edge_sel[2i+1:2i]`: 2'b00 ignores the channel, 2'b01 reacts to 0-to-1, 2'b10 reacts to 1-to-0, 2'b11 reacts to either.
- R3: A qualifying transition on any channel gives exactly one cycle of `hit_valid` high, with `hit_word` equal to the full sample in which the transition was seen.
- R4: With `neg_sel[i]` = 1, channel i is captured on the falling clock edge; a level present only between a rising edge and the next falling edge is then seen, while with `neg_sel[i]` = 0 it is missed.
- R5: An input that changes between rising edge k and the next falling edge gives `hit_valid` and `evt_pulse` high right after rising edge k+2, for either capture choice.
- R6: `evt_pulse` stays high for `pulse_len` clock cycles; a width of 0 is treated as 1.
- R7: A qualifying transition while `evt_pulse` is high restarts the pulse with the full width from that point and sets `overrun`, which then stays 1 until reset.
- R8: Transitions on ignored channels, or in the direction a channel does not select, give no strobe and no pulse.
- R9: Several channels qualifying in the same sample give a single strobe and a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; rising edge is the active edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | NCH (32) | Input channels |
| edge_sel | input | 2*NCH (64) | Two-bit reaction mode per channel |
| neg_sel | input | NCH (32) | Per channel: 1 captures on the falling edge |
| pulse_len | input | PW_W (8) | Event pulse width in clock cycles |
| hit_valid | output | 1 | One-cycle strobe on a detected change |
| hit_word | output | NCH (32) | Sample word that held the change |
| evt_pulse | output | 1 | Event pulse |
| overrun | output | 1 | Sticky: a change arrived during a running pulse |

## Verification
Inputs are driven 1 ns after a rising edge, so a change is captured at the next rising edge (or the falling edge before it) and the strobe with its word is due right after the second rising edge that follows; the bench advances exactly two edges before each strobe check and one more edge to see it drop. The pulse is counted from that same sample point, one sample per cycle, and must read high exactly the programmed number of times. The falling-edge capture case drops the input again before the next rising edge, so only the falling-edge sample can explain a strobe.

// File: rtl/chg_detect_pkg.sv
package chg_detect_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/chg_sampler.sv
module chg_sampler #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] din,
  input  logic [NCH-1:0] neg_sel,
  output logic [NCH-1:0] cur,
  output logic [NCH-1:0] prev
);
  logic [NCH-1:0] neg_q;
  logic [NCH-1:0] cur_q, cur_d;
  logic [NCH-1:0] prev_q;

  // inactive-edge capture
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= '0;
    else        neg_q <= din;
  end

  // per-channel choice of capture point, carried into the active domain
  always_comb begin
    cur_d = (neg_sel & neg_q) | (~neg_sel & din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= cur_d;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/chg_qualifier.sv
module chg_qualifier
  import chg_detect_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   cur,
  input  logic [NCH-1:0]   prev,
  input  logic [2*NCH-1:0] edge_sel,
  output logic             hit_now,
  output logic             hit_valid,
  output logic [NCH-1:0]   hit_word
);
  logic [NCH-1:0] match;
  logic           valid_q;
  logic [NCH-1:0] word_q, word_d;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    edge_mode_e mode;
    logic       rise, fall;
    assign mode = edge_mode_e'(edge_sel[2*i +: 2]);
    assign rise = cur[i] & ~prev[i];
    assign fall = ~cur[i] & prev[i];
    always_comb begin
      unique case (mode)
        EDGE_RISE: match[i] = rise;
        EDGE_FALL: match[i] = fall;
        EDGE_ANY:  match[i] = rise | fall;
        default:   match[i] = 1'b0;
      endcase
    end
  end

  assign hit_now = |match;

  always_comb begin
    word_d = hit_now ? cur : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= hit_now;
      word_q  <= word_d;
    end
  end

  assign hit_valid = valid_q;
  assign hit_word  = word_q;

  // R3: a strobe needs a difference between the two samples one cycle before
  a_r3_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> $past(cur != prev));
endmodule

// File: rtl/chg_pulse_gen.sv
module chg_pulse_gen #(
  parameter int PW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic [PW_W-1:0] pulse_len,
  output logic            evt,
  output logic            overrun
);
  localparam logic [PW_W-1:0] ONE = PW_W'(1);

  logic [PW_W-1:0] cnt_q, cnt_d, load_val;
  logic            ovr_q, ovr_d;

  always_comb begin
    load_val = (pulse_len == '0) ? ONE : pulse_len;
    if (hit)                cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - ONE;
    else                    cnt_d = cnt_q;
    ovr_d = ovr_q | (hit & (cnt_q != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  assign evt     = (cnt_q != '0);
  assign overrun = ovr_q;

  // R7: the flag never clears outside reset
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R6: a pulse never starts without a hit
  a_r6_no_spontaneous: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !hit) |=> !evt);
endmodule

// File: rtl/chg_detect_unit.sv
module chg_detect_unit #(
  parameter int NCH  = 32,
  parameter int PW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   din,
  input  logic [2*NCH-1:0] edge_sel,
  input  logic [NCH-1:0]   neg_sel,
  input  logic [PW_W-1:0]  pulse_len,
  output logic             hit_valid,
  output logic [NCH-1:0]   hit_word,
  output logic             evt_pulse,
  output logic             overrun
);
  logic           rst_s1, rst_s2;
  logic [NCH-1:0] cur, prev;
  logic           hit_now;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  chg_sampler #(.NCH(NCH)) u_samp (
    .clk(clk), .rst_n(rst_s2), .din(din), .neg_sel(neg_sel),
    .cur(cur), .prev(prev)
  );

  chg_qualifier #(.NCH(NCH)) u_qual (
    .clk(clk), .rst_n(rst_s2), .cur(cur), .prev(prev), .edge_sel(edge_sel),
    .hit_now(hit_now), .hit_valid(hit_valid), .hit_word(hit_word)
  );

  chg_pulse_gen #(.PW_W(PW_W)) u_pulse (
    .clk(clk), .rst_n(rst_s2), .hit(hit_now), .pulse_len(pulse_len),
    .evt(evt_pulse), .overrun(overrun)
  );

  // R5: strobe and pulse start together
  a_r5_pulse_with_strobe: assert property (@(posedge clk) disable iff (!rst_s2)
    hit_valid |-> evt_pulse);
  // R1: outputs quiet in the cycle after reset is released
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    (!rst_s2) |=> (!hit_valid && !overrun));
endmodule

// File: tb/tb_chg_detect_unit.sv
module tb_chg_detect_unit;
  localparam int  NCH  = 32;
  localparam int  PW_W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NCH-1:0]   din;
  logic [2*NCH-1:0] edge_sel;
  logic [NCH-1:0]   neg_sel;
  logic [PW_W-1:0]  pulse_len;
  logic             hit_valid;
  logic [NCH-1:0]   hit_word;
  logic             evt_pulse;
  logic             overrun;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_detect_unit #(.NCH(NCH), .PW_W(PW_W)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .edge_sel(edge_sel),
    .neg_sel(neg_sel), .pulse_len(pulse_len), .hit_valid(hit_valid),
    .hit_word(hit_word), .evt_pulse(evt_pulse), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // advance to 1 ns after the next rising edge
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1ns;
    end
  endtask

  task automatic set_mode(input int ch, input logic [1:0] m);
    edge_sel[2*ch +: 2] = m;
  endtask

  task automatic all_modes(input logic [1:0] m);
    for (int c = 0; c < NCH; c++) edge_sel[2*c +: 2] = m;
  endtask

  // count high samples starting at the current one
  task automatic pulse_width(output int w);
    w = 0;
    while (evt_pulse && w < 300) begin
      w++;
      step();
    end
  endtask

  task automatic expect_no_hit(input string req, input int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (hit_valid || evt_pulse) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset;
    check(hit_valid == 1'b0, "R1", hit_valid, 0);
    check(evt_pulse == 1'b0, "R1", evt_pulse, 0);
    check(overrun == 1'b0, "R1", overrun, 0);
    check(hit_word == '0, "R1", hit_word, 0);
  endtask

  task automatic t_rise_basic;
    int w;
    all_modes(2'b01);
    pulse_len = 8'd4;
    din[3] = 1'b1;
    step(2);
    check(hit_valid == 1'b1, "R5", hit_valid, 1);
    check(evt_pulse == 1'b1, "R5", evt_pulse, 1);
    check(hit_word == 32'h8, "R3", hit_word, 32'h8);
    pulse_width(w);
    check(w == 4, "R6", w, 4);
    // falling change on a rising-only channel
    din[3] = 1'b0;
    expect_no_hit("R8", 6);
  endtask

  task automatic t_modes;
    all_modes(2'b00);
    set_mode(31, 2'b10);
    set_mode(0, 2'b11);
    pulse_len = 8'd2;
    step();
    din[5] = 1'b1;           // ignored channel
    expect_no_hit("R8", 4);
    din[5] = 1'b0;
    din[31] = 1'b1;          // rise on a falling-only channel
    expect_no_hit("R2", 4);
    din[31] = 1'b0;          // fall: qualifies
    step(2);
    check(hit_valid == 1'b1, "R2", hit_valid, 1);
    check(hit_word == 32'h0, "R3", hit_word, 0);
    step(4);
    din[0] = 1'b1;           // either-edge channel, rise
    step(2);
    check(hit_valid == 1'b1 && hit_word == 32'h1, "R2", hit_word, 1);
    step(4);
    din[0] = 1'b0;           // either-edge channel, fall
    step(2);
    check(hit_valid == 1'b1 && hit_word == 32'h0, "R2", hit_valid, 1);
    step(4);
  endtask

  task automatic t_multi;
    int strobes = 0;
    all_modes(2'b11);
    pulse_len = 8'd3;
    din = 32'hA000_0011;
    step(2);
    check(hit_word == 32'hA000_0011, "R9", hit_word, 32'hA000_0011);
    for (int i = 0; i < 6; i++) begin
      if (hit_valid) strobes++;
      step();
    end
    check(strobes == 1, "R9", strobes, 1);
    check(overrun == 1'b0, "R9", overrun, 0);
    din = '0;
    step(8);
  endtask

  task automatic t_neg_capture;
    all_modes(2'b01);
    pulse_len = 8'd1;
    neg_sel = '0;
    neg_sel[7] = 1'b1;
    step();
    // high only between rising edge and falling edge, channel 7
    din[7] = 1'b1;
    #6ns din[7] = 1'b0;
    #3ns;
    step();
    check(hit_valid == 1'b1 && hit_word == 32'h80, "R4", hit_word, 32'h80);
    step(4);
    // same glitch on a rising-edge channel
    din[9] = 1'b1;
    #6ns din[9] = 1'b0;
    #3ns;
    expect_no_hit("R4", 4);
    // stable change on a falling-edge channel: same latency as the direct path
    din[7] = 1'b1;
    step(2);
    check(hit_valid == 1'b1 && evt_pulse == 1'b1, "R5", hit_valid, 1);
    din[7] = 1'b0;
    neg_sel = '0;
    step(4);
  endtask

  task automatic t_zero_width;
    int w;
    all_modes(2'b01);
    pulse_len = 8'd0;
    din[12] = 1'b1;
    step(2);
    pulse_width(w);
    check(w == 1, "R6", w, 1);
    din[12] = 1'b0;
    step(3);
  endtask

  task automatic t_overrun;
    int w;
    all_modes(2'b01);
    pulse_len = 8'd5;
    check(overrun == 1'b0, "R7", overrun, 0);
    din[20] = 1'b1;
    step(2);                 // first strobe
    din[21] = 1'b1;          // second change two cycles later
    step(2);
    check(hit_valid == 1'b1, "R7", hit_valid, 1);
    check(overrun == 1'b1, "R7", overrun, 1);
    pulse_width(w);
    check(w == 5, "R7", w, 5);
    step(3);
    check(overrun == 1'b1, "R7", overrun, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    din = '0;
    edge_sel = '0;
    neg_sel = '0;
    pulse_len = '0;
    #1ns;
    t_reset();
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_rise_basic();
    t_modes();
    t_multi();
    t_neg_capture();
    t_zero_width();
    t_overrun();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule